// File: doc/BRIEF.md
# Set-Associative Translation Cache

This block holds recently used virtual-to-physical translations so that a master's address path can skip a table walk. It has 64 sets of 8 ways, and each entry records a 4 KiB, 64 KiB or 1 MiB mapping. Every page size picks its set from virtual bits [17:12]. A large mapping is therefore stored in the set chosen by the address that caused its fill. A later access to a different 4 KiB slice of the same mapping can land in another set, miss, and trigger another fill. A 64 KiB mapping can end up in up to 16 sets this way, and a 1 MiB mapping in all 64.

Lookup is combinational: `lk_va` goes in and hit, multi-hit, physical address and page size come out in the same cycle. Fills and invalidations take effect at the next rising edge. A per-page invalidate clears every way in the addressed set that matches the address. To remove a large mapping completely, software issues one invalidate per 4 KiB page, up to 64 of them. A flush-all request runs a sweep that clears one set per cycle.

The controller has two states. In `ST_RUN`, lookups, fills and invalidates are served. `ST_SWEEP` clears one set per cycle and holds `busy` high. There are three transitions. `ST_RUN` goes to `ST_SWEEP` when `flush_all` is high. `ST_SWEEP` stays in `ST_SWEEP` while the sweep index is below 63. `ST_SWEEP` goes to `ST_RUN` after set 63 has been cleared.

Top module: `tlb_cache`

## Requirements
- R1: With `lk_valid` high, a lookup whose virtual tag matches exactly one valid way of set `lk_va[17:12]` sets `lk_hit` in the same cycle. A 4 KiB entry returns `lk_pa = {stored_ppn, lk_va[11:0]}` and `lk_size = 2'b00`. On a miss, `lk_hit`, `lk_pa` and `lk_size` are zero.
- R2: An entry is only found through the set selected by the fill address bits [17:12]. A lookup with the same page but different bits [17:12] misses. The tag comparison ignores virtual bits [15:12] for a 64 KiB entry (size code 2'b01) and bits [19:12] for a 1 MiB entry (size code 2'b10).
- R3: On a hit to a 64 KiB entry, physical bits [15:0] come from the virtual address and the upper bits from the stored frame. On a hit to a 1 MiB entry, physical bits [19:0] come from the virtual address.
- R4: If more than one valid way of the selected set matches, `lk_multi` is 1 and `lk_hit` is 0.
- R5: An accepted fill is visible to a lookup from the next cycle on. It takes the lowest-numbered free way of its set. A fill with size code 2'b11 is ignored.
- R6: With `lru_en` high, a fill into a full set replaces the least-recently-used way. Both hits and fills make a way most recently used.
- R7: With `lru_en` low, a fill into a full set replaces the way named by a global rotating pointer. The pointer starts at 0 and advances by one on each such replacement, and lookups do not change the choice.
- R8: An invalidate whose command bit 0 is 1 clears every way of set `inv_cmd[17:12]` that matches `inv_cmd[31:12]` under that way's size mask. A command with bit 0 clear has no effect.
- R9: A `flush_all` pulse holds `busy` high for exactly 64 cycles, starting in the cycle after the request. Afterwards every lookup misses.
- R10: While `busy` is high, lookups report neither a hit nor a multi-hit, and fills and invalidates are ignored.
- R11: Priority is flush-all over invalidate over fill. A fill presented in the same cycle as an accepted invalidate is dropped.
- R12: After reset every way is invalid and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lru_en | input | 1 | 1: least-recently-used replacement; 0: rotating pointer |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Single matching way found |
| lk_multi | output | 1 | More than one way matched |
| lk_pa | output | 32 | Translated physical address |
| lk_size | output | 2 | Page size of the hit: 00 4 KiB, 01 64 KiB, 10 1 MiB |
| fill_valid | input | 1 | Insert request |
| fill_va | input | 32 | Virtual address of the walked page |
| fill_pa | input | 32 | Physical address of the walked page |
| fill_size | input | 2 | Size code of the new entry; 11 is reserved |
| inv_valid | input | 1 | Per-page invalidate request |
| inv_cmd | input | 32 | Page-aligned virtual address; bit 0 is the valid marker |
| flush_all | input | 1 | Invalidate every entry |
| busy | output | 1 | Flush sweep in progress |

## Verification
The assertions assume that lookups of a just-filled or just-invalidated page occur while no sweep is running. They also assume that a lookup in the cycle after a fill or an invalidate uses an address whose tag can be compared with the one that was written or removed. The bench drives each request for exactly one cycle, changing inputs only on falling edges. It raises `flush_all` only while the controller is in `ST_RUN` and waits for `busy` to drop before continuing. The only requests it issues during a sweep are the deliberate ones that check R10.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        PG_4K   = 2'b00,
        PG_64K  = 2'b01,
        PG_1M   = 2'b10,
        PG_RSVD = 2'b11
    } pg_size_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_SWEEP = 1'b1
    } tlb_state_e;
endpackage

// File: rtl/tlb_way_match.sv
module tlb_way_match
    import tlb_pkg::*;
#(
    parameter int TAG_W      = 20,
    parameter int LARGE_BITS = 4,
    parameter int SECT_BITS  = 8
) (
    input  logic             valid,
    input  logic [TAG_W-1:0] tag_stored,
    input  logic [1:0]       size,
    input  logic [TAG_W-1:0] tag_in,
    output logic             match
);
    logic [TAG_W-1:0] cmp_mask;

    always_comb begin
        cmp_mask = '1;
        if (size == PG_64K)
            cmp_mask[LARGE_BITS-1:0] = '0;
        else if (size == PG_1M)
            cmp_mask[SECT_BITS-1:0] = '0;
        match = valid && (((tag_stored ^ tag_in) & cmp_mask) == '0);
    end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int SETS = 64,
    parameter int WAYS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    touch_en,
    input  logic [$clog2(SETS)-1:0] touch_set,
    input  logic [$clog2(WAYS)-1:0] touch_way,
    input  logic [$clog2(SETS)-1:0] query_set,
    output logic [$clog2(WAYS)-1:0] victim_way
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAYS-1:0]  oldest_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_q[touch_set][w] <= '0;
                else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
            end
        end
    end

    always_comb begin
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            oldest_vec[w] = (age_q[query_set][w] == WAY_W'(WAYS - 1));
            if (oldest_vec[w])
                victim_way = WAY_W'(w);
        end
    end

    // R6: the ages of a set stay a permutation, so exactly one way is oldest
    assert_lru_single_oldest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1);

    logic [SET_W-1:0] unused_w;
    assign unused_w = '0;
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
    import tlb_pkg::*;
#(
    parameter int VA_W        = 32,
    parameter int PA_W        = 32,
    parameter int WAYS        = 8,
    parameter int SETS        = 64,
    parameter int PG_SHIFT    = 12,
    parameter int LARGE_SHIFT = 16,
    parameter int SECT_SHIFT  = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lru_en,
    input  logic            lk_valid,
    input  logic [VA_W-1:0] lk_va,
    output logic            lk_hit,
    output logic            lk_multi,
    output logic [PA_W-1:0] lk_pa,
    output logic [1:0]      lk_size,
    input  logic            fill_valid,
    input  logic [VA_W-1:0] fill_va,
    input  logic [PA_W-1:0] fill_pa,
    input  logic [1:0]      fill_size,
    input  logic            inv_valid,
    input  logic [VA_W-1:0] inv_cmd,
    input  logic            flush_all,
    output logic            busy
);
    localparam int SET_W      = $clog2(SETS);
    localparam int WAY_W      = $clog2(WAYS);
    localparam int TAG_W      = VA_W - PG_SHIFT;
    localparam int PPN_W      = PA_W - PG_SHIFT;
    localparam int LARGE_BITS = LARGE_SHIFT - PG_SHIFT;
    localparam int SECT_BITS  = SECT_SHIFT - PG_SHIFT;

    // storage
    logic [WAYS-1:0]  vld_q [SETS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [PPN_W-1:0] ppn_q [SETS][WAYS];
    logic [1:0]       sz_q  [SETS][WAYS];

    // controller
    tlb_state_e       state_q, state_d;
    logic [SET_W-1:0] sweep_q, sweep_d;
    logic [WAY_W-1:0] rr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            sweep_q <= '0;
        end else begin
            state_q <= state_d;
            sweep_q <= sweep_d;
        end
    end

    always_comb begin
        state_d = state_q;
        sweep_d = sweep_q;
        unique case (state_q)
            ST_RUN: begin
                if (flush_all) begin
                    state_d = ST_SWEEP;
                    sweep_d = '0;
                end
            end
            ST_SWEEP: begin
                sweep_d = sweep_q + 1'b1;
                if (sweep_q == SET_W'(SETS - 1))
                    state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    logic run;
    always_comb begin
        busy = (state_q == ST_SWEEP);
        run  = (state_q == ST_RUN);
    end

    // address fields
    logic [SET_W-1:0] lk_set, fill_set, inv_set;
    logic [TAG_W-1:0] lk_tag, inv_tag;
    assign lk_set   = lk_va[PG_SHIFT +: SET_W];
    assign fill_set = fill_va[PG_SHIFT +: SET_W];
    assign inv_set  = inv_cmd[PG_SHIFT +: SET_W];
    assign lk_tag   = lk_va[VA_W-1:PG_SHIFT];
    assign inv_tag  = inv_cmd[VA_W-1:PG_SHIFT];

    // per-way comparators for lookup and invalidate
    logic [WAYS-1:0] lk_match, inv_match;
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tlb_way_match #(.TAG_W(TAG_W), .LARGE_BITS(LARGE_BITS), .SECT_BITS(SECT_BITS)) i_lk_cmp (
            .valid(vld_q[lk_set][w]), .tag_stored(tag_q[lk_set][w]),
            .size(sz_q[lk_set][w]), .tag_in(lk_tag), .match(lk_match[w]));
        tlb_way_match #(.TAG_W(TAG_W), .LARGE_BITS(LARGE_BITS), .SECT_BITS(SECT_BITS)) i_inv_cmp (
            .valid(vld_q[inv_set][w]), .tag_stored(tag_q[inv_set][w]),
            .size(sz_q[inv_set][w]), .tag_in(inv_tag), .match(inv_match[w]));
    end

    // lookup result
    logic [WAY_W-1:0] lk_sel;
    logic [PPN_W-1:0] ppn_out;
    logic [1:0]       sz_sel;
    logic             single_hit;

    always_comb begin
        lk_sel = '0;
        for (int w = 0; w < WAYS; w++)
            if (lk_match[w])
                lk_sel = WAY_W'(w);
        single_hit = run && lk_valid && ($countones(lk_match) == 1);
        lk_multi   = run && lk_valid && ($countones(lk_match) > 1);
        lk_hit     = single_hit;
        sz_sel     = sz_q[lk_set][lk_sel];
        ppn_out    = ppn_q[lk_set][lk_sel];
        if (sz_sel == PG_64K)
            ppn_out[LARGE_BITS-1:0] = lk_tag[LARGE_BITS-1:0];
        else if (sz_sel == PG_1M)
            ppn_out[SECT_BITS-1:0] = lk_tag[SECT_BITS-1:0];
        lk_pa   = single_hit ? {ppn_out, lk_va[PG_SHIFT-1:0]} : '0;
        lk_size = single_hit ? sz_sel : 2'b00;
    end

    // request acceptance, priority flush > invalidate > fill
    logic inv_go, fill_go, set_full;
    logic [WAY_W-1:0] free_way, lru_way, victim;

    always_comb begin
        inv_go   = run && !flush_all && inv_valid && inv_cmd[0];
        fill_go  = run && !flush_all && !inv_go && fill_valid && (fill_size != PG_RSVD);
        set_full = &vld_q[fill_set];
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (!vld_q[fill_set][w])
                free_way = WAY_W'(w);
        if (!set_full)
            victim = free_way;
        else if (lru_en)
            victim = lru_way;
        else
            victim = rr_q;
    end

    // recency tracking
    logic             touch_en;
    logic [SET_W-1:0] touch_set;
    logic [WAY_W-1:0] touch_way;

    always_comb begin
        touch_en  = fill_go || single_hit;
        touch_set = fill_go ? fill_set : lk_set;
        touch_way = fill_go ? victim : lk_sel;
    end

    tlb_lru #(.SETS(SETS), .WAYS(WAYS)) i_lru (
        .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_set(touch_set),
        .touch_way(touch_way), .query_set(fill_set), .victim_way(lru_way));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rr_q <= '0;
        else if (fill_go && set_full && !lru_en)
            rr_q <= rr_q + 1'b1;
    end

    // valid bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                vld_q[s] <= '0;
        end else if (busy) begin
            vld_q[sweep_q] <= '0;
        end else begin
            if (inv_go)
                vld_q[inv_set] <= vld_q[inv_set] & ~inv_match;
            if (fill_go)
                vld_q[fill_set][victim] <= 1'b1;
        end
    end

    // entry contents
    always_ff @(posedge clk) begin
        if (fill_go) begin
            tag_q[fill_set][victim] <= fill_va[VA_W-1:PG_SHIFT];
            ppn_q[fill_set][victim] <= fill_pa[PA_W-1:PG_SHIFT];
            sz_q[fill_set][victim]  <= fill_size;
        end
    end

    // R9: nothing survives a completed sweep
    assert_sweep_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !lk_hit && !lk_multi);

    // R10: lookups are blind during the sweep
    assert_busy_no_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !lk_hit && !lk_multi);

    // R5: an accepted fill is found by the next lookup of that page
    assert_fill_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_go |=> (!lk_valid || lk_va[VA_W-1:PG_SHIFT] != $past(fill_va[VA_W-1:PG_SHIFT])
                     || lk_hit || lk_multi));

    // R8: an accepted invalidate leaves no match for that page
    assert_inv_removes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inv_go |=> (lk_va[VA_W-1:PG_SHIFT] != $past(inv_cmd[VA_W-1:PG_SHIFT])
                    || (!lk_hit && !lk_multi)));
endmodule

// File: tb/test_tlb_cache.sv
module test_tlb_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lru_en = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_va = '0;
    logic        lk_hit, lk_multi;
    logic [31:0] lk_pa;
    logic [1:0]  lk_size;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_va = '0, fill_pa = '0;
    logic [1:0]  fill_size = '0;
    logic        inv_valid = 1'b0;
    logic [31:0] inv_cmd = '0;
    logic        flush_all = 1'b0;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tlb_cache i_tlb_cache (
        .clk(clk), .rst_n(rst_n), .lru_en(lru_en), .lk_valid(lk_valid), .lk_va(lk_va),
        .lk_hit(lk_hit), .lk_multi(lk_multi), .lk_pa(lk_pa), .lk_size(lk_size),
        .fill_valid(fill_valid), .fill_va(fill_va), .fill_pa(fill_pa), .fill_size(fill_size),
        .inv_valid(inv_valid), .inv_cmd(inv_cmd), .flush_all(flush_all), .busy(busy));

    localparam logic [1:0] OP_FILL = 2'd0, OP_LOOK = 2'd1, OP_INV = 2'd2, OP_FLUSH = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] va;
        logic [31:0] pa;
        logic [1:0]  sz;
        logic        hit;
        logic        multi;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VEC [NVEC] = '{
        '{OP_LOOK,  32'h0000_5123, 32'h0,          2'd0, 1'b0, 1'b0},
        '{OP_FILL,  32'h0000_5000, 32'h8000_3000,  2'd0, 1'b0, 1'b0},
        '{OP_LOOK,  32'h0000_5abc, 32'h8000_3abc,  2'd0, 1'b1, 1'b0},
        '{OP_LOOK,  32'h0000_6abc, 32'h0,          2'd0, 1'b0, 1'b0},
        '{OP_FILL,  32'h0012_3000, 32'h4560_0000,  2'd1, 1'b0, 1'b0},
        '{OP_LOOK,  32'h0012_3010, 32'h4560_3010,  2'd1, 1'b1, 1'b0},
        '{OP_LOOK,  32'h0012_4010, 32'h0,          2'd0, 1'b0, 1'b0},
        '{OP_FILL,  32'h0340_0000, 32'h0770_0000,  2'd2, 1'b0, 1'b0},
        '{OP_LOOK,  32'h0348_0044, 32'h0778_0044,  2'd2, 1'b1, 1'b0},
        '{OP_LOOK,  32'h0340_1000, 32'h0,          2'd0, 1'b0, 1'b0},
        '{OP_INV,   32'h0348_0001, 32'h0,          2'd0, 1'b0, 1'b0},
        '{OP_LOOK,  32'h0340_0000, 32'h0,          2'd0, 1'b0, 1'b0},
        '{OP_INV,   32'h0000_5000, 32'h0,          2'd0, 1'b0, 1'b0},
        '{OP_LOOK,  32'h0000_5004, 32'h8000_3004,  2'd0, 1'b1, 1'b0},
        '{OP_INV,   32'h0000_5001, 32'h0,          2'd0, 1'b0, 1'b0},
        '{OP_LOOK,  32'h0000_5004, 32'h0,          2'd0, 1'b0, 1'b0},
        '{OP_LOOK,  32'h0012_3ffc, 32'h4560_3ffc,  2'd1, 1'b1, 1'b0},
        '{OP_FLUSH, 32'h0,         32'h0,          2'd0, 1'b0, 1'b0},
        '{OP_LOOK,  32'h0012_3ffc, 32'h0,          2'd0, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] va, input bit hit, input bit multi,
                        input logic [31:0] pa, input logic [1:0] sz, input string req);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_va    = va;
        #1;
        chk(lk_hit == hit, req, "hit", 32'(lk_hit), 32'(hit));
        chk(lk_multi == multi, req, "multi", 32'(lk_multi), 32'(multi));
        if (hit) begin
            chk(lk_pa == pa, req, "pa", lk_pa, pa);
            chk(lk_size == sz, req, "size", 32'(lk_size), 32'(sz));
        end
        @(posedge clk);
        #1 lk_valid = 1'b0;
    endtask

    task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz);
        @(negedge clk);
        fill_valid = 1'b1; fill_va = va; fill_pa = pa; fill_size = sz;
        @(posedge clk);
        #1 fill_valid = 1'b0;
    endtask

    task automatic inv(input logic [31:0] cmd);
        @(negedge clk);
        inv_valid = 1'b1; inv_cmd = cmd;
        @(posedge clk);
        #1 inv_valid = 1'b0;
    endtask

    task automatic flush();
        @(negedge clk);
        flush_all = 1'b1;
        @(posedge clk);
        #1 flush_all = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int busy_cycles;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(busy == 1'b0, "R12", "busy after reset", 32'(busy), 32'h0);
        rst_n = 1'b1;
        look(32'h0000_0000, 1'b0, 1'b0, '0, 2'd0, "R12");

        // table walk: R1/R2/R3/R8/R9 basic behaviour
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i].op)
                OP_FILL:  fill(VEC[i].va, VEC[i].pa, VEC[i].sz);
                OP_LOOK:  look(VEC[i].va, VEC[i].hit, VEC[i].multi, VEC[i].pa, VEC[i].sz,
                               $sformatf("R1/R2/R3/R8/R9 step %0d", i));
                OP_INV:   inv(VEC[i].va);
                default:  flush();
            endcase
        end

        // R6: LRU replacement in set 5
        lru_en = 1'b1;
        for (int i = 0; i < 8; i++) fill((i << 18) | 32'h5000, 32'h1000_0000 + (i << 12), 2'd0);
        look(32'h0000_5000, 1'b1, 1'b0, 32'h1000_0000, 2'd0, "R6");
        fill((8 << 18) | 32'h5000, 32'h1000_8000, 2'd0);
        look((1 << 18) | 32'h5000, 1'b0, 1'b0, '0, 2'd0, "R6");
        look(32'h0000_5000, 1'b1, 1'b0, 32'h1000_0000, 2'd0, "R6");
        look((8 << 18) | 32'h5000, 1'b1, 1'b0, 32'h1000_8000, 2'd0, "R6");

        // R7: rotating replacement in set 9
        flush();
        lru_en = 1'b0;
        for (int i = 0; i < 8; i++) fill((i << 18) | 32'h9000, 32'h2000_0000 + (i << 12), 2'd0);
        look(32'h0000_9000, 1'b1, 1'b0, 32'h2000_0000, 2'd0, "R7");
        fill((8 << 18) | 32'h9000, 32'h2000_8000, 2'd0);
        look(32'h0000_9000, 1'b0, 1'b0, '0, 2'd0, "R7");
        look((1 << 18) | 32'h9000, 1'b1, 1'b0, 32'h2000_1000, 2'd0, "R7");
        fill((9 << 18) | 32'h9000, 32'h2000_9000, 2'd0);
        look((1 << 18) | 32'h9000, 1'b0, 1'b0, '0, 2'd0, "R7");
        lru_en = 1'b1;

        // R4: duplicate fill gives multi-hit; R8 invalidate clears both
        fill(32'h0000_c000, 32'h3000_0000, 2'd0);
        fill(32'h0000_c000, 32'h3000_1000, 2'd0);
        look(32'h0000_c010, 1'b0, 1'b1, '0, 2'd0, "R4");
        inv(32'h0000_c001);
        look(32'h0000_c010, 1'b0, 1'b0, '0, 2'd0, "R8");

        // R5: reserved size is ignored
        fill(32'h0001_4000, 32'h3300_0000, 2'd3);
        look(32'h0001_4000, 1'b0, 1'b0, '0, 2'd0, "R5");

        // R11: invalidate beats fill in the same cycle
        fill(32'h0001_e000, 32'h3400_0000, 2'd0);
        @(negedge clk);
        inv_valid = 1'b1; inv_cmd = 32'h0001_e001;
        fill_valid = 1'b1; fill_va = 32'h0001_f000; fill_pa = 32'h3500_0000; fill_size = 2'd0;
        @(posedge clk);
        #1 begin inv_valid = 1'b0; fill_valid = 1'b0; end
        look(32'h0001_e000, 1'b0, 1'b0, '0, 2'd0, "R11");
        look(32'h0001_f000, 1'b0, 1'b0, '0, 2'd0, "R11");

        // R9/R10: sweep length and blindness while busy
        fill(32'h0002_0000, 32'h3600_0000, 2'd0);
        @(negedge clk);
        flush_all = 1'b1;
        @(posedge clk);
        #1 flush_all = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R9", "busy after request", 32'(busy), 32'h1);
        lk_valid = 1'b1; lk_va = 32'h0002_0000;
        fill_valid = 1'b1; fill_va = 32'h0002_1000; fill_pa = 32'h3700_0000; fill_size = 2'd0;
        #1;
        chk(lk_hit == 1'b0, "R10", "hit while busy", 32'(lk_hit), 32'h0);
        @(posedge clk);
        #1 begin lk_valid = 1'b0; fill_valid = 1'b0; end
        busy_cycles = 1;
        @(negedge clk);
        while (busy) begin
            busy_cycles++;
            @(negedge clk);
        end
        chk(busy_cycles == 64, "R9", "busy length", 32'(busy_cycles), 32'd64);
        look(32'h0002_0000, 1'b0, 1'b0, '0, 2'd0, "R9");
        look(32'h0002_1000, 1'b0, 1'b0, '0, 2'd0, "R10");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule